// File: doc/BRIEF.md
# Peripheral Control Register Bank

This block is the register bank that sits between the processor bus and a set of on-chip peripherals. It stores twenty 16-bit control words. Each word has its own mask of writable bits and its own reset value. Some words behave specially:

- an interrupt-flag word whose bits are cleared by writing ones;
- a keypad word that reports live key state, active low;
- write-only words that read back the bus's open-bus value;
- two 32-bit address registers built from pairs of halfwords.

A byte write to one dedicated address is not stored. It asks the processor to halt or to stop instead.

The bus side has a single-cycle write strobe with two byte enables and a read strobe whose data is returned, registered, on the next cycle. The peripheral side receives three one-cycle strobes: halt, stop, and a 32-bit update pulse. The update pulse carries the assembled 32-bit value and says which register pair it came from. The video, audio, DMA and timer engines that consume these words sit outside the block.

Top module: `periph_regbank`

## Requirements
- R1: The register index is byte address bits [5:1]. The map by index is: 0 display control, 1 display status, 2 and 3 scroll offsets, 4 to 7 scaling matrix A/B/C/D, 8 master sound control, 9 sound bias, 10/11 transfer source low/high, 12/13 transfer destination low/high, 14 timer control, 15 keypad, 16 interrupt enable, 17 interrupt flags, 18 wait control, 19 master interrupt enable. On a write, byteEn[0] selects wrData[7:0] and byteEn[1] selects wrData[15:8]. A lane that is not enabled keeps its stored byte before the register's mask is applied. A read returns its data on rdData one cycle after rdEn.
- R2: After reset, index 0 reads 0x0080, index 9 reads 0x0200, indices 4 and 7 read 0x0100, and every other readable word reads 0.
- R3: A write to index 17 clears each flag bit that is 1 in an enabled lane of wrData; all other flag bits are kept. Each 1 on irqRaise sets that flag bit, and a raise wins over a clear in the same cycle.
- R4: A write with byteEn[0] set to byte address 40 (index 20) is not stored. If wrData[7] is 0, haltReq pulses for one cycle. If wrData[7] is 1, stopReq pulses for one cycle. The pulse appears in the cycle after the write.
- R5: Display status (index 1) has write mask 0xFFF8; its low 3 bits never change on a write.
- R6: The keypad word (index 15) reads as ~keysDown zero-extended to 16 bits, so with no key pressed it reads 0x03FF. Writes to it change nothing.
- R7: Master sound control (index 8) takes only bit 7 from a write. All its other bits, including the low 4, keep their value.
- R8: Timer control (index 14) has write mask 0x00C7, and master interrupt enable (index 19) has write mask 0x0001. All other ordinary words take all 16 bits.
- R9: A write to either half of a transfer source or destination register stores that half. In the next cycle wideUpd pulses for one cycle and wideData carries {stored high half, stored low half}, using the new half. wideSel is 0 for source and 1 for destination.
- R10: A read of a write-only word (indices 2, 3, 10, 11, 12, 13) or of any index of 20 or above returns the value of openBus in the read cycle.
- R11: Writes to indices above 20 change no register and produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Single-cycle write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 6 | Byte address; bits [5:1] pick the word |
| byteEn | input | 2 | Byte-lane enables for writes |
| wrData | input | 16 | Write data |
| openBus | input | 16 | Value returned for unreadable words |
| keysDown | input | 10 | Key state, 1 = pressed |
| irqRaise | input | 16 | Interrupt flag set pulses |
| rdData | output | 16 | Registered read data |
| haltReq | output | 1 | Halt request pulse |
| stopReq | output | 1 | Stop request pulse |
| wideUpd | output | 1 | 32-bit register updated pulse |
| wideSel | output | 1 | 0 source pair, 1 destination pair |
| wideData | output | 32 | Assembled 32-bit value |

## Verification
A corrupted stored word stays hidden until it is read. It then shows on rdData one cycle after the read strobe, or, for the write-only pairs, on wideData when the other half is written. The bench therefore writes a pattern to every index and reads it back at once. A flaw in decode or in a mask is visible within two cycles of the write. A wrong strobe shows in the cycle directly after the write that caused it, so every write checks all strobe outputs at that cycle.

// File: rtl/prb_pkg.sv
package prb_pkg;
  localparam int IDX_W    = 5;
  localparam int NUM_REGS = 20;
  typedef logic [IDX_W-1:0] idx_t;

  localparam idx_t R_DISP = 5'd0;
  localparam idx_t R_STAT = 5'd1;
  localparam idx_t R_SCRX = 5'd2;
  localparam idx_t R_SCRY = 5'd3;
  localparam idx_t R_MA   = 5'd4;
  localparam idx_t R_MD   = 5'd7;
  localparam idx_t R_SND  = 5'd8;
  localparam idx_t R_BIAS = 5'd9;
  localparam idx_t R_SRCL = 5'd10;
  localparam idx_t R_SRCH = 5'd11;
  localparam idx_t R_DSTL = 5'd12;
  localparam idx_t R_DSTH = 5'd13;
  localparam idx_t R_TMR  = 5'd14;
  localparam idx_t R_KEY  = 5'd15;
  localparam idx_t R_IFL  = 5'd17;
  localparam idx_t R_IME  = 5'd19;
  localparam idx_t R_PWR  = 5'd20;
  localparam idx_t LAST_IDX = idx_t'(NUM_REGS - 1);

  typedef struct packed {
    logic       wr;
    idx_t       wIdx;
    logic [1:0] be;
    logic       rd;
    idx_t       rIdx;
    logic       rMapped;
  } strobe_t;

  function automatic logic [15:0] resetVal(idx_t i);
    case (i)
      R_DISP:     return 16'h0080;
      R_BIAS:     return 16'h0200;
      R_MA, R_MD: return 16'h0100;
      default:    return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] wrMask(idx_t i);
    case (i)
      R_STAT:  return 16'hFFF8;
      R_SND:   return 16'h0080;
      R_TMR:   return 16'h00C7;
      R_KEY:   return 16'h0000;
      R_IME:   return 16'h0001;
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic logic writeOnly(idx_t i);
    case (i)
      R_SCRX, R_SCRY, R_SRCL, R_SRCH, R_DSTL, R_DSTH: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/prb_ctrl.sv
module prb_ctrl
  import prb_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        byteEn,
  input  logic              stopBit,
  output strobe_t           stb,
  output logic              haltReq,
  output logic              stopReq
);
  localparam int HW_W = ADDR_W - 1;
  localparam logic [HW_W-1:0] HW_LAST = HW_W'(NUM_REGS - 1);
  localparam logic [HW_W-1:0] HW_PWR  = HW_W'(R_PWR);

  logic [HW_W-1:0] hwIdx;
  logic inMap, pwrHit;

  always_comb begin
    hwIdx       = addr[ADDR_W-1:1];
    inMap       = (hwIdx <= HW_LAST);
    pwrHit      = wrEn && (hwIdx == HW_PWR) && byteEn[0];
    stb.wr      = wrEn && inMap && (|byteEn);
    stb.wIdx    = hwIdx[IDX_W-1:0];
    stb.be      = byteEn;
    stb.rd      = rdEn;
    stb.rIdx    = hwIdx[IDX_W-1:0];
    stb.rMapped = inMap;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haltReq <= 1'b0;
      stopReq <= 1'b0;
    end else begin
      haltReq <= pwrHit && !stopBit;
      stopReq <= pwrHit && stopBit;
    end
  end

  p_pwr_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(haltReq && stopReq));
  p_halt_src_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(haltReq) |-> $past(wrEn && byteEn[0]));
  p_oob_r11: assert property (@(posedge clk) disable iff (!rstN)
    stb.wr |-> (hwIdx <= HW_LAST));
endmodule

// File: rtl/prb_dpath.sv
module prb_dpath
  import prb_pkg::*;
#(
  parameter int KEY_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [15:0]      wrData,
  input  logic [15:0]      openBus,
  input  logic [KEY_W-1:0] keysDown,
  input  logic [15:0]      irqRaise,
  output logic [15:0]      rdData,
  output logic             wideUpd,
  output logic             wideSel,
  output logic [31:0]      wideData
);
  logic [15:0] regs [NUM_REGS];
  logic [15:0] curWord, laneMask, merged, keyWord, readVal;
  logic [31:0] wideNext;
  logic        wideHit, wideSelNext;

  always_comb begin
    curWord  = (stb.wIdx <= LAST_IDX) ? regs[stb.wIdx] : 16'h0;
    laneMask = {{8{stb.be[1]}}, {8{stb.be[0]}}};
    merged   = (wrData & laneMask) | (curWord & ~laneMask);
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam idx_t        MY_IDX = idx_t'(i);
    localparam logic [15:0] MASK   = wrMask(MY_IDX);
    localparam logic [15:0] RST    = resetVal(MY_IDX);
    logic hit;
    assign hit = stb.wr && (stb.wIdx == MY_IDX);
    if (MY_IDX == R_IFL) begin : g_flag
      always_ff @(posedge clk) begin
        if (!rstN) regs[i] <= RST;
        else regs[i] <= (hit ? (regs[i] & ~(wrData & laneMask)) : regs[i]) | irqRaise;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rstN)    regs[i] <= RST;
        else if (hit) regs[i] <= (regs[i] & ~MASK) | (merged & MASK);
      end
    end
  end

  always_comb begin
    wideHit     = 1'b0;
    wideSelNext = 1'b0;
    wideNext    = 32'h0;
    case (stb.wIdx)
      R_SRCL: begin wideHit = stb.wr; wideNext = {regs[R_SRCH], merged}; end
      R_SRCH: begin wideHit = stb.wr; wideNext = {merged, regs[R_SRCL]}; end
      R_DSTL: begin wideHit = stb.wr; wideSelNext = 1'b1; wideNext = {regs[R_DSTH], merged}; end
      R_DSTH: begin wideHit = stb.wr; wideSelNext = 1'b1; wideNext = {merged, regs[R_DSTL]}; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wideUpd  <= 1'b0;
      wideSel  <= 1'b0;
      wideData <= 32'h0;
    end else begin
      wideUpd <= wideHit;
      if (wideHit) begin
        wideSel  <= wideSelNext;
        wideData <= wideNext;
      end
    end
  end

  always_comb begin
    keyWord              = 16'h0;
    keyWord[KEY_W-1:0]   = ~keysDown;
    if (!stb.rMapped || writeOnly(stb.rIdx)) readVal = openBus;
    else if (stb.rIdx == R_KEY)              readVal = keyWord;
    else                                     readVal = regs[stb.rIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN)       rdData <= 16'h0;
    else if (stb.rd) rdData <= readVal;
  end

  p_w1c_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wr && stb.wIdx == R_IFL && irqRaise == 16'h0)
      |=> ((regs[R_IFL] & $past(wrData & laneMask)) == 16'h0));
  p_stat_ro_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wr && stb.wIdx == R_STAT) |=> $stable(regs[R_STAT][2:0]));
  p_snd_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wr && stb.wIdx == R_SND) |=> $stable(regs[R_SND][6:0]));
  p_wide_src_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wideUpd) |-> $past(stb.wr));
endmodule

// File: rtl/periph_regbank.sv
module periph_regbank
  import prb_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int KEY_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        byteEn,
  input  logic [15:0]       wrData,
  input  logic [15:0]       openBus,
  input  logic [KEY_W-1:0]  keysDown,
  input  logic [15:0]       irqRaise,
  output logic [15:0]       rdData,
  output logic              haltReq,
  output logic              stopReq,
  output logic              wideUpd,
  output logic              wideSel,
  output logic [31:0]       wideData
);
  strobe_t stb;

  prb_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .byteEn(byteEn), .stopBit(wrData[7]), .stb(stb),
    .haltReq(haltReq), .stopReq(stopReq)
  );

  prb_dpath #(.KEY_W(KEY_W)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .openBus(openBus),
    .keysDown(keysDown), .irqRaise(irqRaise), .rdData(rdData),
    .wideUpd(wideUpd), .wideSel(wideSel), .wideData(wideData)
  );
endmodule

// File: tb/periph_regbank_tb.sv
module periph_regbank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [5:0] addr = '0;
  logic [1:0] byteEn = '0;
  logic [15:0] wrData = '0, openBus = '0, irqRaise = '0;
  logic [9:0] keysDown = '0;
  logic [15:0] rdData;
  logic haltReq, stopReq, wideUpd, wideSel;
  logic [31:0] wideData;

  int nChecks = 0, nErr = 0;
  logic [15:0] m [20];

  always #(CLK_PERIOD/2) clk = ~clk;

  periph_regbank dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .byteEn(byteEn), .wrData(wrData), .openBus(openBus), .keysDown(keysDown),
    .irqRaise(irqRaise), .rdData(rdData), .haltReq(haltReq), .stopReq(stopReq),
    .wideUpd(wideUpd), .wideSel(wideSel), .wideData(wideData)
  );

  function automatic logic [15:0] bMask(int i);
    case (i)
      1: return 16'hFFF8;  8: return 16'h0080; 14: return 16'h00C7;
      15: return 16'h0000; 19: return 16'h0001;
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic logic [15:0] bRst(int i);
    case (i)
      0: return 16'h0080; 9: return 16'h0200; 4, 7: return 16'h0100;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic bit bWo(int i);
    return (i == 2 || i == 3 || (i >= 10 && i <= 13));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(int hw, logic [1:0] be, logic [15:0] d, string req);
    logic [15:0] lm, cur, mg;
    bit expW, expH, expS, expSel;
    logic [31:0] expWD;
    expW = 0; expH = 0; expS = 0; expSel = 0; expWD = '0;
    lm = {{8{be[1]}}, {8{be[0]}}};
    if (hw < 20 && be != 2'b00) begin
      cur = m[hw];
      mg = (d & lm) | (cur & ~lm);
      if (hw == 17) m[hw] = cur & ~(d & lm);
      else m[hw] = (cur & ~bMask(hw)) | (mg & bMask(hw));
      if (hw >= 10 && hw <= 13) begin
        expW = 1; expSel = (hw >= 12);
        expWD = (hw == 10 || hw == 12) ? {m[hw+1], m[hw]} : {m[hw], m[hw-1]};
      end
    end
    if (hw == 20 && be[0]) begin expH = !d[7]; expS = d[7]; end
    m[17] = m[17] | irqRaise;
    addr = 6'(hw * 2); byteEn = be; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    check({req, " halt"}, {31'b0, haltReq}, {31'b0, expH});
    check({req, " stop"}, {31'b0, stopReq}, {31'b0, expS});
    check({req, " wideUpd"}, {31'b0, wideUpd}, {31'b0, expW});
    if (expW) begin
      check({req, " wideData"}, wideData, expWD);
      check({req, " wideSel"}, {31'b0, wideSel}, {31'b0, expSel});
    end
  endtask

  task automatic doRead(int hw, string req);
    logic [15:0] ob, exp;
    ob = 16'hB00F ^ 16'(hw * 16'h0111);
    if (hw >= 20 || bWo(hw)) exp = ob;
    else if (hw == 15) exp = {6'b0, ~keysDown};
    else exp = m[hw];
    addr = 6'(hw * 2); openBus = ob; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    check(req, {16'b0, rdData}, {16'b0, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nErr++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    logic [15:0] pats [4];
    pats[0] = 16'hFFFF; pats[1] = 16'h0000; pats[2] = 16'hA5C3; pats[3] = 16'h5A3C;
    for (int i = 0; i < 20; i++) m[i] = bRst(i);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R2 reset values, R10 open bus, R6 idle keypad 0x3FF
    for (int i = 0; i < 22; i++) doRead(i, "R2_R10 reset read");

    // R1 R5 R7 R8 R9 full-word sweep
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < 20; i++) begin
        doWrite(i, 2'b11, pats[p], "R1 word write");
        doRead(i, "R1_R5_R7_R8 readback");
      end

    // R1 byte-lane merge sweep
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < 20; i++) begin
        doWrite(i, 2'b01, pats[p] ^ 16'h1234, "R1 low byte");
        doRead(i, "R1 low byte merge");
        doWrite(i, 2'b10, pats[p] ^ 16'h8421, "R1 high byte");
        doRead(i, "R1 high byte merge");
      end

    // R9 pairs assembled from halves
    doWrite(10, 2'b11, 16'h1111, "R9 src lo");
    doWrite(11, 2'b11, 16'h2222, "R9 src hi");
    doWrite(13, 2'b11, 16'h4444, "R9 dst hi");
    doWrite(12, 2'b01, 16'h0033, "R9 dst lo byte");

    // R3 interrupt flags
    irqRaise = 16'hF0F0;
    m[17] = m[17] | irqRaise;
    @(negedge clk);
    irqRaise = 16'h0;
    doRead(17, "R3 raise");
    doWrite(17, 2'b11, 16'h3030, "R3 clear");
    doRead(17, "R3 w1c");
    doWrite(17, 2'b01, 16'hFFFF, "R3 lane clear");
    doRead(17, "R3 lane w1c keeps high byte");
    irqRaise = 16'h8000;
    doWrite(17, 2'b11, 16'h8000, "R3 raise beats clear");
    irqRaise = 16'h0;
    doRead(17, "R3 raise priority");

    // R4 power control
    doWrite(20, 2'b01, 16'h0000, "R4 halt");
    doWrite(20, 2'b01, 16'h0080, "R4 stop");
    doWrite(20, 2'b10, 16'hFFFF, "R4 high lane no strobe");
    for (int i = 0; i < 20; i++) doRead(i, "R4 not stored");

    // R6 keypad sweep
    for (int k = 0; k < 10; k++) begin
      keysDown = 10'(1 << k) | 10'(k * 37);
      doRead(15, "R6 keypad");
    end
    doWrite(15, 2'b11, 16'h0000, "R6 keypad write");
    doRead(15, "R6 keypad write ignored");

    // R11 out-of-range writes
    for (int i = 21; i < 32; i++) doWrite(i, 2'b11, 16'hFFFF, "R11 oob write");
    for (int i = 0; i < 20; i++) doRead(i, "R11 unchanged");

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule